// File: doc/BRIEF.md
# Inter-Core Doorbell Mailbox Hub

This block lets the cores of a multi-core cluster raise interrupts on one another. Each core owns a group of 32-bit mailbox words, and every bit of a word is a separate doorbell. A sender writes a mask through the set window, and those bits are ORed into the target mailbox. The receiver reads the mailbox through the clear window, picks the lowest set bit, and acknowledges it by writing that single bit back to the clear window. Only the bits that are 1 in a clear mask are removed.

Each core has an enable register. Each of its low bits enables one of that core's mailboxes. A core's interrupt output is high while any enabled mailbox of that core holds a nonzero value. All accesses use a single 32-bit register port. Reads return their data one cycle later.

Address map with the default parameters (byte addresses, 8-bit address):

| Window | Range | Word selected |
|---|---|---|
| enable | 0x00 + 4*core | enable register of that core |
| set | 0x40 + 16*core + 4*mailbox | mailbox (write ORs mask in) |
| clear | 0x80 + 16*core + 4*mailbox | mailbox (write clears mask bits, read returns contents) |
| unused | 0xC0 and above | nothing |

Top module: `core_doorbell_hub`

## Requirements
- R1: After reset, all mailboxes and enable registers are zero and every irq_out bit is low.
- R2: A write to set address 0x40 + 16*core + 4*mbox ORs bus_wdata into that mailbox. Bits that were already set stay set.
- R3: A write to clear address 0x80 + 16*core + 4*mbox clears exactly the bits that are 1 in bus_wdata and leaves every other bit of that mailbox unchanged.
- R4: A read of a clear-window address returns that mailbox's contents on bus_rdata, with bus_rvalid high, in the cycle after bus_rd. bus_rvalid is low in every other cycle.
- R5: Each write reaches only the one mailbox that its core and mailbox offsets select. The other mailboxes keep their values.
- R6: The enable register of core c is at 0x00 + 4*c. Bit m (m = 0..3) enables mailbox m of that core. Writes to bits 4..31 are dropped, and those bits read as zero.
- R7: irq_out[c] is high exactly one cycle after the cycle in which some mailbox m of core c is nonzero and its enable bit m is set. Otherwise irq_out[c] is low.
- R8: Reads of the set window and of the unused window (0xC0 and above) return zero. Writes to the unused window change no mailbox and no enable register.
- R9: The acknowledge flow works for pending doorbells: clearing the lowest set bit leaves the higher pending bits visible, and the interrupt stays high until the last enabled bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data or mask |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | High in the cycle that bus_rdata is valid |
| irq_out | output | 4 | Per-core mailbox interrupt |

## Verification
The bench uses the default build: four cores with four mailboxes each, 32-bit words and an 8-bit address. With these values all sixteen mailbox words, all four enable registers and all four address windows can be reached, including the unused top quarter of the address space. Random set, clear, enable and read traffic against a bench model covers overlapping masks and cross-core isolation. Directed cases cover the lowest-bit acknowledge sequence, the upper enable bits and writes to unmapped addresses.

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;
  typedef enum logic [1:0] {
    WIN_ENABLE = 2'd0,
    WIN_SET    = 2'd1,
    WIN_CLEAR  = 2'd2,
    WIN_NONE   = 2'd3
  } win_e;
endpackage

// File: rtl/doorbell_decode.sv
module doorbell_decode
  import doorbell_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_CORES = 4,
  parameter int MBOX_PER  = 4
) (
  input  logic [ADDR_W-1:0]                         addr,
  output win_e                                      win,
  output logic [$clog2(NUM_CORES*MBOX_PER)-1:0]     word_idx,
  output logic                                      core_ok
);
  localparam int WORDS  = NUM_CORES * MBOX_PER;
  localparam int IDX_W  = $clog2(WORDS);
  localparam int WIN_LG = IDX_W + 2;

  logic [ADDR_W-1:0] top_bits;
  logic [ADDR_W-1:0] word_bits;
  logic [ADDR_W-1:0] above;

  always_comb begin
    top_bits  = addr >> WIN_LG;
    word_bits = addr >> 2;
    above     = addr >> (WIN_LG + 2);
    word_idx  = word_bits[IDX_W-1:0];
    core_ok   = ({1'b0, word_idx} < (IDX_W+1)'(NUM_CORES));
    if (above != '0) win = WIN_NONE;
    else             win = win_e'(top_bits[1:0]);
  end
endmodule

// File: rtl/doorbell_bank.sv
module doorbell_bank #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 16,
  parameter int IDX_W  = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          set_en,
  input  logic                          clr_en,
  input  logic [IDX_W-1:0]              idx,
  input  logic [DATA_W-1:0]             mask,
  output logic [WORDS-1:0][DATA_W-1:0]  mbox
);
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic hit;
    logic [DATA_W-1:0] set_m, clr_m;
    always_comb begin
      hit   = (idx == IDX_W'(w));
      set_m = (set_en && hit) ? mask : '0;
      clr_m = (clr_en && hit) ? mask : '0;
    end
    always_ff @(posedge clk) begin
      if (rst) mbox[w] <= '0;
      else     mbox[w] <= (mbox[w] & ~clr_m) | set_m;
    end
  end
endmodule

// File: rtl/doorbell_irq.sv
module doorbell_irq #(
  parameter int DATA_W    = 32,
  parameter int NUM_CORES = 4,
  parameter int MBOX_PER  = 4
) (
  input  logic                                          clk,
  input  logic                                          rst,
  input  logic [NUM_CORES-1:0][MBOX_PER-1:0]            enable,
  input  logic [NUM_CORES*MBOX_PER-1:0][DATA_W-1:0]     mbox,
  output logic [NUM_CORES-1:0]                          irq
);
  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic [MBOX_PER-1:0] live;
    for (genvar m = 0; m < MBOX_PER; m++) begin : g_mb
      assign live[m] = enable[c][m] && (mbox[c*MBOX_PER+m] != '0);
    end
    always_ff @(posedge clk) begin
      if (rst) irq[c] <= 1'b0;
      else     irq[c] <= |live;
    end
  end
endmodule

// File: rtl/core_doorbell_hub.sv
module core_doorbell_hub
  import doorbell_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int NUM_CORES = 4,
  parameter int MBOX_PER  = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic                 bus_rvalid,
  output logic [NUM_CORES-1:0] irq_out
);
  localparam int WORDS  = NUM_CORES * MBOX_PER;
  localparam int IDX_W  = $clog2(WORDS);
  localparam int CORE_W = $clog2(NUM_CORES);

  win_e                                   win;
  logic [IDX_W-1:0]                       word_idx;
  logic                                   core_ok;
  logic [CORE_W-1:0]                      core_sel;
  logic [WORDS-1:0][DATA_W-1:0]           mbox_q;
  logic [NUM_CORES-1:0][MBOX_PER-1:0]     ctrl_q;
  logic                                   set_en, clr_en, ctl_en;
  logic [DATA_W-1:0]                      rd_next;

  doorbell_decode #(.ADDR_W(ADDR_W), .NUM_CORES(NUM_CORES), .MBOX_PER(MBOX_PER)) u_dec (
    .addr(bus_addr), .win(win), .word_idx(word_idx), .core_ok(core_ok)
  );

  assign core_sel = word_idx[CORE_W-1:0];
  assign set_en   = bus_wr && (win == WIN_SET);
  assign clr_en   = bus_wr && (win == WIN_CLEAR);
  assign ctl_en   = bus_wr && (win == WIN_ENABLE) && core_ok;

  doorbell_bank #(.DATA_W(DATA_W), .WORDS(WORDS), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst(rst), .set_en(set_en), .clr_en(clr_en),
    .idx(word_idx), .mask(bus_wdata), .mbox(mbox_q)
  );

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else if (ctl_en) ctrl_q[core_sel] <= bus_wdata[MBOX_PER-1:0];
  end

  doorbell_irq #(.DATA_W(DATA_W), .NUM_CORES(NUM_CORES), .MBOX_PER(MBOX_PER)) u_irq (
    .clk(clk), .rst(rst), .enable(ctrl_q), .mbox(mbox_q), .irq(irq_out)
  );

  always_comb begin
    rd_next = '0;
    if (win == WIN_CLEAR) rd_next = mbox_q[word_idx];
    else if (win == WIN_ENABLE && core_ok) rd_next[MBOX_PER-1:0] = ctrl_q[core_sel];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_next;
    end
  end
endmodule

// File: rtl/doorbell_checker.sv
module doorbell_checker #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int NUM_CORES = 4,
  parameter int MBOX_PER  = 4
) (
  input logic                                       clk,
  input logic                                       rst,
  input logic                                       bus_wr,
  input logic                                       bus_rd,
  input logic [ADDR_W-1:0]                          bus_addr,
  input logic [DATA_W-1:0]                          bus_wdata,
  input logic [DATA_W-1:0]                          bus_rdata,
  input logic                                       bus_rvalid,
  input logic [NUM_CORES-1:0]                       irq_out,
  input logic [NUM_CORES*MBOX_PER-1:0][DATA_W-1:0]  mbox,
  input logic [NUM_CORES-1:0][MBOX_PER-1:0]         ctrl
);
  localparam int WORDS  = NUM_CORES * MBOX_PER;
  localparam int IDX_W  = $clog2(WORDS);
  localparam int WIN_LG = IDX_W + 2;

  logic [ADDR_W-1:0] hi, wd;
  logic [IDX_W-1:0]  idx, idx_d;
  logic              is_set, is_clr, is_rclr;
  logic              set_d, clr_d, rclr_d;
  logic [DATA_W-1:0] mask_d, word_d;
  logic [NUM_CORES-1:0] pend;

  always_comb begin
    hi      = bus_addr >> WIN_LG;
    wd      = bus_addr >> 2;
    idx     = wd[IDX_W-1:0];
    is_set  = bus_wr && (hi == ADDR_W'(1));
    is_clr  = bus_wr && (hi == ADDR_W'(2));
    is_rclr = bus_rd && (hi == ADDR_W'(2));
    for (int c = 0; c < NUM_CORES; c++) begin
      pend[c] = 1'b0;
      for (int m = 0; m < MBOX_PER; m++)
        if (ctrl[c][m] && mbox[c*MBOX_PER+m] != '0) pend[c] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      set_d <= 1'b0; clr_d <= 1'b0; rclr_d <= 1'b0;
      idx_d <= '0; mask_d <= '0; word_d <= '0;
    end else begin
      set_d <= is_set; clr_d <= is_clr; rclr_d <= is_rclr;
      idx_d <= idx; mask_d <= bus_wdata; word_d <= mbox[idx];
    end
  end

  AST_SET_OR: assert property (@(posedge clk) disable iff (rst)
    set_d |-> mbox[idx_d] == (word_d | mask_d)); // R2
  AST_CLEAR_EXACT: assert property (@(posedge clk) disable iff (rst)
    clr_d |-> mbox[idx_d] == (word_d & ~mask_d)); // R3
  AST_CLEAR_READ: assert property (@(posedge clk) disable iff (rst)
    rclr_d |-> bus_rdata == word_d); // R4
  AST_RVALID_ON: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid); // R4
  AST_RVALID_OFF: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> !bus_rvalid); // R4
  AST_IRQ_TRACK: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq_out == $past(pend)); // R7
endmodule

bind core_doorbell_hub doorbell_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CORES(NUM_CORES), .MBOX_PER(MBOX_PER)
) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
  .irq_out(irq_out), .mbox(mbox_q), .ctrl(ctrl_q)
);

// File: tb/test_core_doorbell_hub.sv
module test_core_doorbell_hub;
  localparam int NC = 4;
  localparam int NM = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [NC-1:0] irq_out;

  int checks = 0;
  int fails  = 0;
  logic [31:0] mdl_mb [NC*NM];
  logic [3:0]  mdl_en [NC];

  always #2 clk = ~clk;

  core_doorbell_hub i_core_doorbell_hub (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .irq_out(irq_out)
  );

  function automatic logic [7:0] a_en(int c);          return 8'(4*c); endfunction
  function automatic logic [7:0] a_set(int c, int m);  return 8'(8'h40 + 16*c + 4*m); endfunction
  function automatic logic [7:0] a_clr(int c, int m);  return 8'(8'h80 + 16*c + 4*m); endfunction

  function automatic logic [NC-1:0] exp_irq();
    logic [NC-1:0] r = '0;
    for (int c = 0; c < NC; c++)
      for (int m = 0; m < NM; m++)
        if (mdl_en[c][m] && mdl_mb[c*NM+m] != 0) r[c] = 1'b1;
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0;
    checks++;
    if (bus_rvalid !== 1'b1) begin
      fails++; $display("FAIL R4 rvalid actual=%b expected=1", bus_rvalid);
    end
    d = bus_rdata;
  endtask

  task automatic chk_irq(string req);
    @(negedge clk);
    check(req, 32'(irq_out), 32'(exp_irq()));
  endtask

  task automatic chk_mb(string req, int c, int m);
    logic [31:0] v;
    rd(a_clr(c, m), v);
    check(req, v, mdl_mb[c*NM+m]);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd4242));
    for (int i = 0; i < NC*NM; i++) mdl_mb[i] = '0;
    for (int c = 0; c < NC; c++) mdl_en[c] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    @(negedge clk);
    check("R1 irq", 32'(irq_out), 32'h0);
    check("R1 rvalid", 32'(bus_rvalid), 32'h0);
    for (int c = 0; c < NC; c++) begin
      rd(a_en(c), v); check("R1 enable", v, 32'h0);
      for (int m = 0; m < NM; m++) chk_mb("R1 mailbox", c, m);
    end

    // R2 / R5 directed: OR accumulation on one mailbox only
    wr(a_set(2, 1), 32'h0000_00F0); mdl_mb[9] |= 32'h0000_00F0;
    wr(a_set(2, 1), 32'h8000_0010); mdl_mb[9] |= 32'h8000_0010;
    chk_mb("R2 or", 2, 1);
    chk_mb("R5 neighbour", 2, 0);
    chk_mb("R5 other core", 1, 1);

    // R3 exact clear
    wr(a_clr(2, 1), 32'h0000_0030); mdl_mb[9] &= ~32'h0000_0030;
    chk_mb("R3 clear", 2, 1);

    // R6 upper enable bits dropped
    wr(a_en(1), 32'hFFFF_FFF5); mdl_en[1] = 4'h5;
    rd(a_en(1), v); check("R6 enable", v, 32'h5);
    chk_irq("R6 irq");

    // R7 irq on enabled mailbox, not on disabled
    wr(a_set(1, 1), 32'h1); mdl_mb[5] |= 32'h1;
    chk_irq("R7 disabled mbox");
    check("R7 low", 32'(irq_out[1]), 32'h0);
    wr(a_set(1, 2), 32'h4); mdl_mb[6] |= 32'h4;
    chk_irq("R7 enabled mbox");
    check("R7 high", 32'(irq_out[1]), 32'h1);

    // R9 lowest-first acknowledge on mailbox 0 of core 3
    wr(a_en(3), 32'h1); mdl_en[3] = 4'h1;
    wr(a_set(3, 0), 32'h0000_0A08); mdl_mb[12] |= 32'h0000_0A08;
    for (int k = 0; k < 3; k++) begin
      int low = 0;
      rd(a_clr(3, 0), v);
      check("R9 pending", v, mdl_mb[12]);
      while (!v[low]) low++;
      wr(a_clr(3, 0), 32'h1 << low); mdl_mb[12] &= ~(32'h1 << low);
      chk_irq("R9 irq");
    end
    check("R9 irq released", 32'(irq_out[3]), 32'h0);

    // R8 set window reads zero, unused window ignored
    rd(a_set(2, 1), v); check("R8 set read", v, 32'h0);
    wr(8'hC0, 32'hFFFF_FFFF); wr(8'hC4, 32'hFFFF_FFFF); wr(8'hE4, 32'hFFFF_FFFF);
    rd(8'hC4, v); check("R8 unused read", v, 32'h0);
    chk_mb("R8 mailbox untouched", 0, 1);
    chk_mb("R8 mailbox untouched", 2, 1);
    rd(a_en(0), v); check("R8 enable untouched", v, 32'h0);

    // random traffic
    for (int it = 0; it < 400; it++) begin
      int op = $urandom_range(0, 4);
      int c  = $urandom_range(0, NC-1);
      int m  = $urandom_range(0, NM-1);
      logic [31:0] d = $urandom();
      if ($urandom_range(0, 1) == 1) d = d & $urandom();
      case (op)
        0: begin wr(a_set(c, m), d); mdl_mb[c*NM+m] |= d; end
        1: begin wr(a_clr(c, m), d); mdl_mb[c*NM+m] &= ~d; end
        2: begin wr(a_en(c), d); mdl_en[c] = d[3:0]; end
        3: chk_mb("R4 random read", c, m);
        default: begin rd(a_en(c), v); check("R6 random read", v, 32'(mdl_en[c])); end
      endcase
      chk_irq("R7 random");
    end

    for (int i = 0; i < NC*NM; i++) chk_mb("R5 final", i / NM, i % NM);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule